// File: doc/BRIEF.md
# Sample-Clocked Timers with Dual Interrupt Controller

This block holds three free-running 8-bit timers that advance on a prescaled copy of a 44.1 kHz sample strobe. Every timer that reaches its top count posts a pending flag to two interrupt controllers at once. One controller serves a sound CPU and the other serves a main CPU. Each controller has its own enable, pending and reset registers. The remaining interrupt source positions are fed by one-cycle external event pulses.

The sound CPU side turns its requests into a 3-bit priority level. The level of each source is assembled from one bit in each of three level registers. The main CPU side gets a single request line. Software reaches all of this over a plain 16-bit register bus. Reads are combinational on the word address. Writes take effect on the clock edge.

Top module: `snd_timer_irq`

## Requirements
- R1: After reset, all timer counters and control fields, all enable and pending bits and all level registers are 0, and both interrupt outputs are 0.
- R2: A timer register (word 0 = timer A, 1 = timer B, 2 = timer C) holds a 3-bit rate field in bits 10:8 and an 8-bit count in bits 7:0. A write loads both fields. A read returns them with bits 15:11 as 0.
- R3: With rate field k, the count steps by one every 2^k sample strobes. The strobe count restarts from zero whenever the timer register is written, so the first step comes 2^k strobes after the write.
- R4: The count wraps from 0xFF to 0x00 on its next step and keeps counting.
- R5: A step that brings the count to 0xFF sets the timer's bit in both pending registers: bit 6 for A, 7 for B, 8 for C.
- R6: Writing a reset register (word 5 = sound side, 11 = main side) clears each pending bit written as 1 and leaves bits written as 0 unchanged. A set and a clear of the same bit in the same cycle leave the bit set.
- R7: A pulse on external event input bit n sets pending bit n on both sides, for every n except the timer positions 6, 7 and 8, where the input is ignored.
- R8: The main CPU request is 1 exactly while some bit is set in both the main enable register (word 9) and the main pending register (word 10). Enabling a bit that is already pending raises the request in the cycle after the write.
- R9: The sound CPU level equals the highest level among sources that are both enabled (word 3) and pending (word 4), or 0 when there are none. The level of source n (n < 8) is {word 8 bit n, word 7 bit n, word 6 bit n}. Sources 8 to 10 have level 0.
- R10: Enable and pending registers are 11 bits wide and read as 0 above bit 10. Level registers are 8 bits wide. Reset registers, and words 12 to 15, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-cycle pulse per audio sample period |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| ext_evt | input | 11 | One-cycle event pulses per interrupt source |
| snd_irq_lvl | output | 3 | Sound CPU interrupt level |
| main_irq | output | 1 | Main CPU interrupt request |

## Verification
Two events can hit the same pending bit in one clock: an incoming set, from a timer reaching 0xFF or from an external pulse, and a software clear through a reset register. The bench drives an external pulse and a sound-side reset write for the same bit in one cycle. It then reads the pending register and expects the bit to remain set. The main-side copy, which was not cleared, is read as well to confirm it was set independently.

// File: rtl/snd_irq_pkg.sv
package snd_irq_pkg;
   localparam int NTMR   = 3;
   localparam int ADDR_W = 4;
   localparam int DATA_W = 16;

   localparam logic [ADDR_W-1:0] A_TMR0 = 4'd0;
   localparam logic [ADDR_W-1:0] A_SEN  = 4'd3;
   localparam logic [ADDR_W-1:0] A_SPND = 4'd4;
   localparam logic [ADDR_W-1:0] A_SCLR = 4'd5;
   localparam logic [ADDR_W-1:0] A_LV0  = 4'd6;
   localparam logic [ADDR_W-1:0] A_MEN  = 4'd9;
   localparam logic [ADDR_W-1:0] A_MPND = 4'd10;
   localparam logic [ADDR_W-1:0] A_MCLR = 4'd11;
endpackage

// File: rtl/tmr_unit.sv
module tmr_unit #(
   parameter int CNT_W = 8,
   parameter int CTL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr,
   input  logic [CTL_W-1:0] wr_ctl,
   input  logic [CNT_W-1:0] wr_cnt,
   output logic [CTL_W-1:0] ctl,
   output logic [CNT_W-1:0] cnt,
   output logic             fire
);
   localparam int PRE_W = (1 << CTL_W) - 1;
   localparam logic [CNT_W-1:0] TOP_M1 = {{(CNT_W-1){1'b1}}, 1'b0};

   logic [PRE_W-1:0] pre;
   logic [PRE_W-1:0] lim;
   logic             step;

   assign lim  = PRE_W'(({{PRE_W{1'b0}}, 1'b1} << ctl) - 1'b1);
   assign step = tick && !wr && (pre == lim);
   assign fire = step && (cnt == TOP_M1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
         cnt <= '0;
         pre <= '0;
      end else if (wr) begin
         ctl <= wr_ctl;
         cnt <= wr_cnt;
         pre <= '0;
      end else if (tick) begin
         if (pre == lim) begin
            pre <= '0;
            cnt <= cnt + 1'b1;
         end else begin
            pre <= pre + 1'b1;
         end
      end
   end

   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
   assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr) |=> $stable(cnt));
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
   parameter int NSRC = 11
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_vec,
   input  logic            en_wr,
   input  logic            clr_wr,
   input  logic [NSRC-1:0] wdata,
   output logic [NSRC-1:0] en,
   output logic [NSRC-1:0] pend,
   output logic [NSRC-1:0] req
);
   logic [NSRC-1:0] clr_vec;

   assign clr_vec = clr_wr ? wdata : '0;
   assign req     = en & pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en   <= '0;
         pend <= '0;
      end else begin
         if (en_wr) en <= wdata;
         pend <= (pend & ~clr_vec) | set_vec;
      end
   end

   assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((pend & $past(set_vec)) == $past(set_vec)));
   assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && ((wdata & ~set_vec) != '0)) |=> ((pend & $past(wdata & ~set_vec)) == '0));
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_wr && set_vec == '0) |=> $stable(pend));
endmodule

// File: rtl/lvl_enc.sv
module lvl_enc #(
   parameter int NSRC  = 11,
   parameter int LVL_W = 3
) (
   input  logic [NSRC-1:0]             act,
   input  logic [NSRC-1:0][LVL_W-1:0]  src_lvl,
   output logic [LVL_W-1:0]            lvl
);
   always_comb begin
      lvl = '0;
      for (int n = 0; n < NSRC; n++) begin
         if (act[n] && (src_lvl[n] > lvl)) lvl = src_lvl[n];
      end
   end
endmodule

// File: rtl/snd_timer_irq.sv
module snd_timer_irq
   import snd_irq_pkg::*;
#(
   parameter int NSRC   = 11,
   parameter int NLVL   = 8,
   parameter int CNT_W  = 8,
   parameter int CTL_W  = 3,
   parameter int LVL_W  = 3,
   parameter int TA_BIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_tick,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NSRC-1:0]   ext_evt,
   output logic [LVL_W-1:0]  snd_irq_lvl,
   output logic              main_irq
);
   localparam int TREG_W = CTL_W + CNT_W;

   generate
      if (TA_BIT + NTMR > NSRC) begin : g_bad_pos
         $error("timer pending positions exceed source count");
      end
      if (NLVL > NSRC || NLVL > DATA_W) begin : g_bad_lvl
         $error("level register width out of range");
      end
      if (TREG_W > DATA_W || NSRC > DATA_W) begin : g_bad_w
         $error("register fields exceed bus width");
      end
   endgenerate

   logic [NTMR-1:0]              fire;
   logic [NTMR-1:0][CTL_W-1:0]   t_ctl;
   logic [NTMR-1:0][CNT_W-1:0]   t_cnt;
   logic [NSRC-1:0]              tmr_set;
   logic [NSRC-1:0]              ext_mask;
   logic [NSRC-1:0]              set_vec;

   for (genvar i = 0; i < NTMR; i++) begin : g_tmr
      tmr_unit #(.CNT_W(CNT_W), .CTL_W(CTL_W)) u_tmr (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick   (sample_tick),
         .wr     (bus_wr && bus_addr == A_TMR0 + ADDR_W'(i)),
         .wr_ctl (bus_wdata[TREG_W-1:CNT_W]),
         .wr_cnt (bus_wdata[CNT_W-1:0]),
         .ctl    (t_ctl[i]),
         .cnt    (t_cnt[i]),
         .fire   (fire[i])
      );
   end

   always_comb begin
      tmr_set  = '0;
      ext_mask = '1;
      for (int i = 0; i < NTMR; i++) begin
         tmr_set[TA_BIT+i]  = fire[i];
         ext_mask[TA_BIT+i] = 1'b0;
      end
   end
   assign set_vec = tmr_set | (ext_evt & ext_mask);

   logic [NSRC-1:0] s_en, s_pend, s_req;
   logic [NSRC-1:0] m_en, m_pend, m_req;

   irq_bank #(.NSRC(NSRC)) u_snd (
      .clk (clk), .rst_n (rst_n), .set_vec (set_vec),
      .en_wr  (bus_wr && bus_addr == A_SEN),
      .clr_wr (bus_wr && bus_addr == A_SCLR),
      .wdata  (bus_wdata[NSRC-1:0]),
      .en (s_en), .pend (s_pend), .req (s_req)
   );

   irq_bank #(.NSRC(NSRC)) u_main (
      .clk (clk), .rst_n (rst_n), .set_vec (set_vec),
      .en_wr  (bus_wr && bus_addr == A_MEN),
      .clr_wr (bus_wr && bus_addr == A_MCLR),
      .wdata  (bus_wdata[NSRC-1:0]),
      .en (m_en), .pend (m_pend), .req (m_req)
   );

   logic [LVL_W-1:0][NLVL-1:0] lv_bits;

   for (genvar k = 0; k < LVL_W; k++) begin : g_lv
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lv_bits[k] <= '0;
         else if (bus_wr && bus_addr == A_LV0 + ADDR_W'(k))
            lv_bits[k] <= bus_wdata[NLVL-1:0];
      end
   end

   logic [NSRC-1:0][LVL_W-1:0] src_lvl;

   for (genvar n = 0; n < NSRC; n++) begin : g_src
      if (n < NLVL) begin : g_has
         for (genvar k = 0; k < LVL_W; k++) begin : g_bit
            assign src_lvl[n][k] = lv_bits[k][n];
         end
      end else begin : g_none
         assign src_lvl[n] = '0;
      end
   end

   lvl_enc #(.NSRC(NSRC), .LVL_W(LVL_W)) u_enc (
      .act     (s_req),
      .src_lvl (src_lvl),
      .lvl     (snd_irq_lvl)
   );

   assign main_irq = |m_req;

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NTMR; i++) begin
         if (bus_addr == A_TMR0 + ADDR_W'(i))
            bus_rdata = DATA_W'({t_ctl[i], t_cnt[i]});
      end
      for (int k = 0; k < LVL_W; k++) begin
         if (bus_addr == A_LV0 + ADDR_W'(k)) bus_rdata = DATA_W'(lv_bits[k]);
      end
      case (bus_addr)
         A_SEN:   bus_rdata = DATA_W'(s_en);
         A_SPND:  bus_rdata = DATA_W'(s_pend);
         A_MEN:   bus_rdata = DATA_W'(m_en);
         A_MPND:  bus_rdata = DATA_W'(m_pend);
         default: ;
      endcase
   end

   assert_lvl_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (s_req == '0) |-> (snd_irq_lvl == '0));
   assert_main_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((m_en & m_pend) != '0) |-> main_irq);
   assert_dual_post_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire != '0) |=> ((s_pend & $past(tmr_set)) == $past(tmr_set)
                        && (m_pend & $past(tmr_set)) == $past(tmr_set)));
endmodule

// File: tb/sim_snd_timer_irq.sv
module sim_snd_timer_irq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_tick = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [10:0] ext_evt = '0;
   logic [2:0]  snd_irq_lvl;
   logic        main_irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   snd_timer_irq u0 (
      .clk (clk), .rst_n (rst_n), .sample_tick (sample_tick),
      .bus_wr (bus_wr), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata), .ext_evt (ext_evt),
      .snd_irq_lvl (snd_irq_lvl), .main_irq (main_irq)
   );

   task automatic chk(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [3:0] a, input int exp);
      bus_addr = a;
      #1;
      chk(tag, int'(bus_rdata), exp);
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); sample_tick = 1'b1;
         @(negedge clk); sample_tick = 1'b0;
      end
   endtask

   task automatic pulse(input logic [10:0] v);
      @(negedge clk); ext_evt = v;
      @(negedge clk); ext_evt = '0;
   endtask

   task automatic clear_all();
      wr(4'd5, 16'h07FF);
      wr(4'd11, 16'h07FF);
   endtask

   task automatic t_reset();
      rd_chk("R1 timer A", 4'd0, 0);
      rd_chk("R1 timer C", 4'd2, 0);
      rd_chk("R1 snd pend", 4'd4, 0);
      rd_chk("R1 main pend", 4'd10, 0);
      rd_chk("R1 level reg", 4'd7, 0);
      chk("R1 snd level", snd_irq_lvl, 0);
      chk("R1 main irq", main_irq, 0);
   endtask

   task automatic t_fields();
      wr(4'd0, 16'h0312);
      rd_chk("R2 timer fields", 4'd0, 16'h0312);
      wr(4'd0, 16'hFFFF);
      rd_chk("R2 upper bits zero", 4'd0, 16'h07FF);
      wr(4'd0, 16'h0000);
   endtask

   task automatic t_prescale();
      wr(4'd0, 16'h0210);
      tick(3);
      rd_chk("R3 rate 2 before step", 4'd0, 16'h0210);
      tick(1);
      rd_chk("R3 rate 2 step", 4'd0, 16'h0211);
      wr(4'd0, 16'h0205);
      tick(2);
      wr(4'd0, 16'h0205);
      tick(3);
      rd_chk("R3 prescaler restarts on write", 4'd0, 16'h0205);
      tick(1);
      rd_chk("R3 step after restart", 4'd0, 16'h0206);
      wr(4'd0, 16'h0700);
      tick(127);
      rd_chk("R3 rate 7 before step", 4'd0, 16'h0700);
      tick(1);
      rd_chk("R3 rate 7 step", 4'd0, 16'h0701);
   endtask

   task automatic t_wrap();
      clear_all();
      wr(4'd0, 16'h00FD);
      tick(1);
      rd_chk("R5 no post at FE", 4'd4, 0);
      tick(1);
      rd_chk("R5 count FF", 4'd0, 16'h00FF);
      rd_chk("R5 snd pend timer A", 4'd4, 16'h0040);
      rd_chk("R5 main pend timer A", 4'd10, 16'h0040);
      tick(1);
      rd_chk("R4 wrap to 00", 4'd0, 16'h0000);
      tick(1);
      rd_chk("R4 keeps counting", 4'd0, 16'h0001);
      wr(4'd1, 16'h00FE);
      tick(1);
      rd_chk("R5 timer B bit", 4'd4, 16'h00C0);
      wr(4'd2, 16'h00FE);
      tick(1);
      rd_chk("R5 timer C bit snd", 4'd4, 16'h01C0);
      rd_chk("R5 timer C bit main", 4'd10, 16'h01C0);
      wr(4'd0, 16'h0700);
      wr(4'd1, 16'h0700);
      wr(4'd2, 16'h0700);
      clear_all();
   endtask

   task automatic t_ext();
      pulse(11'h040);
      rd_chk("R7 timer position ignored snd", 4'd4, 0);
      rd_chk("R7 timer position ignored main", 4'd10, 0);
      pulse(11'h409);
      rd_chk("R7 ext snd", 4'd4, 16'h0409);
      rd_chk("R7 ext main", 4'd10, 16'h0409);
   endtask

   task automatic t_clear();
      wr(4'd5, 16'h0000);
      rd_chk("R6 zero write no effect", 4'd4, 16'h0409);
      wr(4'd5, 16'h0001);
      rd_chk("R6 clear bit 0", 4'd4, 16'h0408);
      rd_chk("R6 main untouched", 4'd10, 16'h0409);
      @(negedge clk);
      ext_evt = 11'h001; bus_wr = 1'b1; bus_addr = 4'd5; bus_wdata = 16'h0001;
      @(negedge clk);
      ext_evt = '0; bus_wr = 1'b0;
      rd_chk("R6 set wins over clear", 4'd4, 16'h0409);
      rd_chk("R6 main side set", 4'd10, 16'h0409);
      wr(4'd11, 16'h0400);
      rd_chk("R6 main clear bit 10", 4'd10, 16'h0009);
   endtask

   task automatic t_main();
      #1 chk("R8 no enable no irq", main_irq, 0);
      wr(4'd9, 16'h0008);
      #1 chk("R8 enable pending raises irq", main_irq, 1);
      wr(4'd11, 16'h0008);
      #1 chk("R8 cleared drops irq", main_irq, 0);
      wr(4'd9, 16'h0000);
   endtask

   task automatic t_level();
      wr(4'd6, 16'h0009);
      wr(4'd7, 16'h0001);
      wr(4'd8, 16'hFF08);
      rd_chk("R10 level reg width", 4'd8, 16'h0008);
      #1 chk("R9 none enabled", snd_irq_lvl, 0);
      wr(4'd3, 16'h0001);
      #1 chk("R9 source 0 level 3", snd_irq_lvl, 3);
      wr(4'd3, 16'h0009);
      #1 chk("R9 highest wins", snd_irq_lvl, 5);
      wr(4'd3, 16'h0400);
      #1 chk("R9 source 10 level 0", snd_irq_lvl, 0);
      wr(4'd3, 16'h0008);
      wr(4'd5, 16'h0008);
      #1 chk("R9 cleared source drops", snd_irq_lvl, 0);
      rd_chk("R10 reset reg reads 0", 4'd5, 0);
      rd_chk("R10 unused word", 4'd15, 0);
      wr(4'd3, 16'hFFFF);
      rd_chk("R10 enable width", 4'd3, 16'h07FF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      wr(4'd1, 16'h0700);
      wr(4'd2, 16'h0700);
      t_fields();
      t_prescale();
      t_wrap();
      t_ext();
      t_clear();
      t_main();
      t_level();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule